// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block decides when the backup battery is tested and keeps the result visible on a battery-low line. A test starts on every power-up, which is a rising edge of the supply-nominal input. While main power stays present, a further test runs at a fixed, long interval, 24 hours or more of clock cycles. No test runs while the system runs from the battery. In that state the interval timer is held at zero.

A test is a one-cycle request strobe to an external comparator. A fixed number of cycles later, once the comparator has settled, the block samples the comparator's below-limit flag. The battery-low indication is modelled as the enable of an open-drain driver: high means the pin is pulled low, low means it is released. After a failing test the indication stays on until a later test passes. A status bit tells whether the failure now latched was found at power-up, which makes the stored data suspect, or at a periodic test, which means the battery is near end of life.

Top module: `batt_watch`

## Requirements
- R1: While rst_n is low, chk_req, bl_pull and bl_from_pu are all 0, and they become 0 at once when rst_n falls.
- R2: On the clock edge that first sees supply_ok high after it was low (or after reset), chk_req goes high for exactly one cycle. This is the power-up test.
- R3: While supply_ok stays high, a periodic test strobe follows each previous test strobe exactly INTERVAL_CYC cycles later.
- R4: While supply_ok is low, no strobe is issued and the interval timer is cleared. The interval counting restarts from the power-up strobe that follows.
- R5: batt_below is sampled on the clock edge SETTLE_CYC cycles after the strobe becomes visible. bl_pull (1 = drive the active-low battery-low pin low, 0 = release it) then takes that sampled value. Its value in all other cycles is ignored.
- R6: Between sample edges, bl_pull holds its value, including while supply_ok is low.
- R7: A latched indication clears only when a later test, at power-up or at an interval, samples batt_below = 0.
- R8: bl_from_pu is 1 exactly when the latched failure came from a power-up test. It is 0 for a failure found by a periodic test and 0 whenever bl_pull is 0.
- R9: If supply_ok falls between a strobe and its sample edge, that test is abandoned and bl_pull and bl_from_pu keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Main supply within tolerance |
| batt_below | input | 1 | Comparator flag: battery below limit |
| chk_req | output | 1 | One-cycle test request strobe |
| bl_pull | output | 1 | Open-drain enable for the active-low battery-low pin |
| bl_from_pu | output | 1 | Latched failure came from a power-up test |

## Verification
The bench toggles batt_below to the opposite of the intended result in every cycle except the sample edge. A design that samples one cycle early or late therefore latches the wrong value. It also runs a long wait followed by a power cycle shortly before the interval expires. A timer that is not cleared would fire the next periodic strobe early rather than a full interval after the power-up strobe. The bench drops the supply during the settling window with the battery reported low, which catches a design that latches a failure from an abandoned test. Sequences that move between power-up and periodic failures show whether the source bit is relabelled on each failing test and cleared when a test passes.

// File: rtl/batt_watch.sv
module batt_watch #(
  parameter int unsigned INTERVAL_CYC = 32'd2831155200,
  parameter int unsigned SETTLE_CYC   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic batt_below,
  output logic chk_req,
  output logic bl_pull,
  output logic bl_from_pu
);

  localparam int TW = (INTERVAL_CYC > 1) ? $clog2(INTERVAL_CYC) : 1;
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC + 1) : 1;

  logic          sup_q;
  logic [TW-1:0] tmr;
  logic [SW-1:0] scnt;
  logic          busy;
  logic          kind_pu;

  wire rise  = supply_ok & ~sup_q;
  wire tick  = supply_ok & sup_q & (tmr == TW'(INTERVAL_CYC - 1));
  wire start = rise | tick;
  wire smp   = busy & supply_ok & ~start & (scnt == SW'(SETTLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sup_q   <= 1'b0;
      chk_req <= 1'b0;
    end else begin
      sup_q   <= supply_ok;
      chk_req <= start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                tmr <= '0;
    else if (!supply_ok || start) tmr <= '0;
    else                       tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      scnt    <= '0;
      kind_pu <= 1'b0;
    end else if (!supply_ok) begin
      busy    <= 1'b0;
      scnt    <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      scnt    <= '0;
      kind_pu <= rise;
    end else if (smp) begin
      busy    <= 1'b0;
    end else if (busy) begin
      scnt    <= scnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_pull    <= 1'b0;
      bl_from_pu <= 1'b0;
    end else if (smp) begin
      bl_pull    <= batt_below;
      bl_from_pu <= batt_below & kind_pu;
    end
  end

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_req |=> !chk_req);

  p_rise_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !sup_q) |=> chk_req);

  p_quiet_unpowered_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !chk_req);

  p_timer_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (tmr == '0));

  p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> ($stable(bl_pull) && $stable(bl_from_pu)));

  p_abort_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !busy);

  p_src_needs_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bl_from_pu |-> bl_pull);

endmodule

// File: tb/batt_watch_test.sv
`timescale 1ns/1ps
module batt_watch_test;
  localparam int INTERVAL = 40;
  localparam int SETTLE   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic batt_below = 1'b0;
  logic chk_req, bl_pull, bl_from_pu;

  int total = 0;
  int bad = 0;
  int since = 0;

  always #2 clk = ~clk;

  batt_watch #(.INTERVAL_CYC(INTERVAL), .SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .batt_below(batt_below),
    .chk_req(chk_req), .bl_pull(bl_pull), .bl_from_pu(bl_from_pu));

  // {periodic, below, exp_bl, exp_pu}
  localparam logic [3:0] VEC [9] = '{
    4'b0000, 4'b1110, 4'b1110, 4'b0111, 4'b1000,
    4'b0111, 4'b1110, 4'b0000, 4'b1000 };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_check(input bit periodic, input bit below, input bit ebl, input bit epu);
    logic prev;
    int n;
    batt_below = !below;
    if (!periodic) begin
      @(negedge clk);
      supply_ok = 1'b0;
      prev = bl_pull;
      repeat (4) begin
        @(negedge clk);
        chk(chk_req == 1'b0, "R4 no strobe unpowered", chk_req, 0);
        chk(bl_pull == prev, "R6 hold while unpowered", bl_pull, prev);
      end
      supply_ok = 1'b1;
      @(negedge clk);
      chk(chk_req == 1'b1, "R2 power-up strobe", chk_req, 1);
    end else begin
      n = since;
      do begin
        @(negedge clk);
        n++;
      end while (!chk_req && n < 3 * INTERVAL);
      chk(n == INTERVAL, "R3 interval gap", n, INTERVAL);
    end
    prev = bl_pull;
    for (int i = 1; i < SETTLE; i++) begin
      @(negedge clk);
      chk(bl_pull == prev, "R5 no early sample", bl_pull, prev);
    end
    batt_below = below;
    @(negedge clk);
    chk(bl_pull == ebl, "R5 R7 sampled result", bl_pull, ebl);
    chk(bl_from_pu == epu, "R8 failure source", bl_from_pu, epu);
    batt_below = !below;
    since = SETTLE;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(chk_req == 0 && bl_pull == 0 && bl_from_pu == 0, "R1 reset state",
        {chk_req, bl_pull, bl_from_pu}, 0);
    rst_n = 1'b1;
    repeat (5) begin
      @(negedge clk);
      chk(chk_req == 1'b0, "R4 no strobe before power", chk_req, 0);
    end

    for (int v = 0; v < 9; v++)
      run_check(VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0]);

    // R9: supply lost during settling with battery low
    @(negedge clk);
    supply_ok = 1'b0;
    batt_below = 1'b1;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    @(negedge clk);
    chk(chk_req == 1'b1, "R2 strobe before abort", chk_req, 1);
    supply_ok = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(bl_pull == 1'b0 && bl_from_pu == 1'b0, "R9 abandoned test", bl_pull, 0);
    end
    run_check(1'b0, 1'b0, 1'b0, 1'b0);

    // R4: power cycle just before the interval expires restarts the timer
    repeat (INTERVAL - 10) begin
      @(negedge clk);
      chk(chk_req == 1'b0, "R3 no early strobe", chk_req, 0);
    end
    run_check(1'b0, 1'b1, 1'b1, 1'b1);
    run_check(1'b1, 1'b0, 1'b0, 1'b0);
    run_check(1'b1, 1'b1, 1'b1, 1'b0);

    // R1: reset mid-operation clears latched indication
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(chk_req == 0 && bl_pull == 0 && bl_from_pu == 0, "R1 async reset",
        {chk_req, bl_pull, bl_from_pu}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(chk_req == 1'b1, "R2 strobe after reset with power", chk_req, 1);
    @(negedge clk);
    chk(chk_req == 1'b0, "R2 single-cycle strobe", chk_req, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule